// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Multidrop Address Flag

This block sends eleven-bit asynchronous frames on a single line. A host with a 24-bit data bus places a byte in a one-byte holding register. It picks which byte lane of the bus the byte comes from by using one of three write aliases. A fourth alias takes the low lane and also marks the frame as an address frame: in multidrop mode the ninth bit of that frame goes out high. When multidrop mode is off, the ninth bit carries even parity instead.

Behind the holding register sits the frame shifter. When the shifter has finished the stop bit of the previous frame, the pending byte moves into it without any host action. The empty flag then rises and tells the host that the next byte may be written. The line stays high for a short lead-in of two to four bit times before the start bit. The bit rate comes from an external one-cycle `bitTick` pulse, one pulse per bit time. Because the shifter cannot be observed, the host must wait for the empty flag before each write. A write made while the flag is low replaces the byte that is waiting.

Top module: `mdrop_uart_tx`

## Requirements
- R1: After reset, `txd` is 1 and `tdre` is 1.
- R2: A write with `wrSel` = 0, 1 or 2 stores `wrData[7:0]`, `wrData[15:8]` or `wrData[23:16]` as the byte to be sent.
- R3: A write with `wrSel` = 3 stores `wrData[7:0]` and marks the frame as an address frame. With `multidropEn` = 1, the ninth bit of that frame is 1.
- R4: A write with `wrSel` = 0, 1 or 2 clears the address mark. With `multidropEn` = 1, the ninth bit of that frame is 0.
- R5: `tdre` is 0 in the cycle after any write. It becomes 1 only when the pending byte moves into the shifter, and it stays 1 until the next write.
- R6: A pending byte moves into the shifter only after the stop bit of the previous frame has ended. Frames written in advance therefore follow each other without overlap.
- R7: After a byte moves into the shifter, the line stays high for LEAD_TICKS bit ticks (default 3). The start bit therefore begins 2 to 4 bit times after the transfer, and back-to-back frame starts are (11 + LEAD_TICKS) bit times apart.
- R8: A frame is sent in this order: a start bit of 0, eight data bits, the ninth bit, and a stop bit of 1. Each bit lasts one `bitTick` period, and the line idles at 1.
- R9: With `msbFirst` = 0, the data bits go out bit 0 first. With `msbFirst` = 1, they go out bit 7 first.
- R10: With `multidropEn` = 0, the ninth bit is the XOR of the eight data bits (even parity), and the address mark has no effect.
- R11: A write while `tdre` is 0 replaces the pending byte. The earlier pending byte is never sent.
- R12: If a write falls in the same cycle as the transfer into the shifter, the shifter takes the old byte, the holding register takes the new byte, and `tdre` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle pulse per bit time |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 2 | Alias: 0 low lane, 1 middle lane, 2 high lane, 3 address (low lane) |
| wrData | input | 24 | Host data bus |
| multidropEn | input | 1 | 1: ninth bit is the address mark; 0: ninth bit is even parity |
| msbFirst | input | 1 | 1: data bits go out MSB first |
| txd | output | 1 | Serial output, idles high |
| tdre | output | 1 | Holding register empty |

## Verification
A host write and the automatic move of the pending byte into the shifter can fall in the same clock cycle. The bench provokes this by writing a third byte while a second byte is pending. It counts bit periods from the first frame's start edge and places the write in exactly the cycle after the tick that ends that frame's stop bit. It then expects `tdre` to read 0, and the second and third bytes to go out in that order, with neither one lost nor repeated.

// File: rtl/mdrop_tx_pkg.sv
package mdrop_tx_pkg;

  // Host write aliases; the value selects the bus lane, ALIAS_ADDR also marks the frame.
  typedef enum logic [1:0] {
    ALIAS_LO   = 2'd0,
    ALIAS_MID  = 2'd1,
    ALIAS_HI   = 2'd2,
    ALIAS_ADDR = 2'd3
  } wrAlias_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // move holding byte into the frame shifter
    logic shift;  // advance the frame shifter by one bit
    logic drive;  // frame shifter owns the line
  } txStrobe_t;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 11;

endpackage

// File: rtl/mdrop_tx_dp.sv
module mdrop_tx_dp
  import mdrop_tx_pkg::*;
#(
  parameter int BUS_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [BUS_W-1:0] wrData,
  input  logic             multidropEn,
  input  logic             msbFirst,
  input  txStrobe_t        stb,
  output logic             txd,
  output logic             tdre,
  output logic             holdFull
);

  localparam int NLANES = BUS_W / BYTE_W;
  localparam int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1;

  logic [BYTE_W-1:0]     laneArr [NLANES];
  logic [LANE_W-1:0]     laneIdx;
  logic [BYTE_W-1:0]     laneByte;
  logic [BYTE_W-1:0]     holdByte;
  logic                  addrMark;
  logic                  tdreQ;
  logic [BYTE_W-1:0]     orderedByte;
  logic                  ninthBit;
  logic [FRAME_BITS-1:0] frameQ;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign laneArr[g] = wrData[g*BYTE_W +: BYTE_W];
  end

  // The address alias reads the low lane.
  assign laneIdx  = (wrSel == ALIAS_ADDR) ? '0 : LANE_W'(wrSel);
  assign laneByte = laneArr[laneIdx];

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      orderedByte[i] = msbFirst ? holdByte[BYTE_W-1-i] : holdByte[i];
    end
  end

  assign ninthBit = multidropEn ? addrMark : ^holdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
      addrMark <= 1'b0;
    end else if (wrEn) begin
      holdByte <= laneByte;
      addrMark <= (wrSel == ALIAS_ADDR);
    end
  end

  // A write in the transfer cycle wins: the new byte stays pending.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tdreQ <= 1'b1;
    else if (wrEn)     tdreQ <= 1'b0;
    else if (stb.load) tdreQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameQ <= '1;
    else if (stb.load)  frameQ <= {1'b1, ninthBit, orderedByte, 1'b0};
    else if (stb.shift) frameQ <= {1'b1, frameQ[FRAME_BITS-1:1]};
  end

  assign txd      = stb.drive ? frameQ[0] : 1'b1;
  assign tdre     = tdreQ;
  assign holdFull = !tdreQ;

endmodule

// File: rtl/mdrop_tx_ctrl.sv
module mdrop_tx_ctrl
  import mdrop_tx_pkg::*;
#(
  parameter int LEAD_TICKS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      holdFull,
  output txStrobe_t stb
);

  localparam int LEAD_W = $clog2(LEAD_TICKS + 1);
  localparam int CNT_W  = $clog2(FRAME_BITS + 1);
  localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0]  BIT_LAST  = CNT_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SEND} txState_e;

  txState_e          state;
  logic [LEAD_W-1:0] leadCnt;
  logic [CNT_W-1:0]  bitCnt;

  always_comb begin
    stb       = '0;
    stb.load  = (state == ST_IDLE) && holdFull;
    stb.drive = (state == ST_SEND);
    stb.shift = (state == ST_SEND) && bitTick && (bitCnt != BIT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      leadCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (holdFull) begin
            state   <= ST_LEAD;
            leadCnt <= '0;
          end
        end
        ST_LEAD: begin
          if (bitTick) begin
            if (leadCnt == LEAD_LAST) begin
              state  <= ST_SEND;
              bitCnt <= '0;
            end else begin
              leadCnt <= leadCnt + 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (bitTick) begin
            if (bitCnt == BIT_LAST) state  <= ST_IDLE;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdrop_uart_tx.sv
module mdrop_uart_tx
  import mdrop_tx_pkg::*;
#(
  parameter int BUS_W      = 24,
  parameter int LEAD_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [BUS_W-1:0] wrData,
  input  logic             multidropEn,
  input  logic             msbFirst,
  output logic             txd,
  output logic             tdre
);

  txStrobe_t stb;
  logic      holdFull;

  mdrop_tx_ctrl #(.LEAD_TICKS(LEAD_TICKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .holdFull (holdFull),
    .stb      (stb)
  );

  mdrop_tx_dp #(.BUS_W(BUS_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .multidropEn (multidropEn),
    .msbFirst    (msbFirst),
    .stb         (stb),
    .txd         (txd),
    .tdre        (tdre),
    .holdFull    (holdFull)
  );

endmodule

// File: rtl/mdrop_uart_tx_chk.sv
module mdrop_uart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic txd,
  input logic tdre
);

  // R5: every write empties the flag one cycle later
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !tdre);

  // R5: only a write can take the flag down
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (tdre && !wrEn) |=> tdre);

  // R12: a transfer never raises the flag in a cycle that carried a write
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tdre) |-> !$past(wrEn));

  // R6: transfer happens only with the line idle, never mid-frame
  a_r6_load_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tdre) |-> (txd && $past(txd)));

endmodule

bind mdrop_uart_tx mdrop_uart_tx_chk u_chk (
  .clk  (clk),
  .rstN (rstN),
  .wrEn (wrEn),
  .txd  (txd),
  .tdre (tdre)
);

// File: tb/mdrop_uart_tx_bench.sv
module mdrop_uart_tx_bench;

  localparam int BIT  = 8;
  localparam int LEAD = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [23:0] wrData = '0;
  logic        multidropEn = 1'b1;
  logic        msbFirst = 1'b0;
  logic        txd;
  logic        tdre;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastWrCyc = 0;
  bit done   = 1'b0;

  mdrop_uart_tx u_mdrop_uart_tx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .multidropEn(multidropEn), .msbFirst(msbFirst),
    .txd(txd), .tdre(tdre)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (BIT-1) @(negedge clk);
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
    end
  end

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] expFrame(input logic [7:0] d, input logic ninth, input logic msb);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = msb ? d[7-i] : d[i];
    f[9]  = ninth;
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic hostWrite(input logic [1:0] sel, input logic [23:0] data);
    @(negedge clk);
    lastWrCyc = cyc;
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Samples each bit mid-period; optionally writes in the cycle the next transfer happens.
  task automatic captureFrame(output logic [10:0] bits, output int startCyc,
                              input bit hit, input logic [1:0] hitSel, input logic [23:0] hitData);
    do @(negedge clk); while (txd !== 1'b0);
    startCyc = cyc;
    repeat (BIT/2) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < 11; k++) begin
      repeat (BIT) @(negedge clk);
      bits[k] = txd;
    end
    if (hit) begin
      repeat (BIT/2 - 1) @(negedge clk);
      hostWrite(hitSel, hitData);
    end
  endtask

  task automatic settle();
    repeat (2*BIT) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 txd after reset", txd, 1'b1);
    checkEq("R1 tdre after reset", tdre, 1'b1);
  endtask

  task automatic testLanes();
    logic [10:0] f;
    int s;
    logic [7:0] exp [3];
    exp[0] = 8'h5A; exp[1] = 8'h96; exp[2] = 8'h3C;
    multidropEn = 1'b1; msbFirst = 1'b0;
    for (int l = 0; l < 3; l++) begin
      hostWrite(2'(l), 24'h3C965A);
      if (l == 0) begin
        checkEq("R5 tdre low after write", tdre, 1'b0);
        @(negedge clk);
        checkEq("R5 tdre high after transfer", tdre, 1'b1);
      end
      captureFrame(f, s, 1'b0, 2'd0, '0);
      checkEq("R2 R4 R8 lane frame", f, expFrame(exp[l], 1'b0, 1'b0));
      if (l == 0) begin
        checkEq("R7 lead-in at least 2 bit times", (s - lastWrCyc >= 2*BIT + 2), 1'b1);
        checkEq("R7 lead-in at most 4 bit times", (s - lastWrCyc <= 4*BIT + 2), 1'b1);
      end
      settle();
    end
  endtask

  task automatic testAddress();
    logic [10:0] f;
    int s;
    multidropEn = 1'b1; msbFirst = 1'b0;
    hostWrite(2'd3, 24'hFFFF81);
    captureFrame(f, s, 1'b0, 2'd0, '0);
    checkEq("R3 address frame ninth bit set", f, expFrame(8'h81, 1'b1, 1'b0));
    settle();
    hostWrite(2'd0, 24'h000081);
    captureFrame(f, s, 1'b0, 2'd0, '0);
    checkEq("R4 lane write clears address bit", f, expFrame(8'h81, 1'b0, 1'b0));
    settle();
  endtask

  task automatic testParity();
    logic [10:0] f;
    int s;
    multidropEn = 1'b0; msbFirst = 1'b0;
    hostWrite(2'd3, 24'h000007);
    captureFrame(f, s, 1'b0, 2'd0, '0);
    checkEq("R10 odd data gives parity 1, mark ignored", f, expFrame(8'h07, 1'b1, 1'b0));
    settle();
    hostWrite(2'd3, 24'h000003);
    captureFrame(f, s, 1'b0, 2'd0, '0);
    checkEq("R10 even data gives parity 0, mark ignored", f, expFrame(8'h03, 1'b0, 1'b0));
    settle();
    multidropEn = 1'b1;
  endtask

  task automatic testMsbFirst();
    logic [10:0] f;
    int s;
    msbFirst = 1'b1;
    hostWrite(2'd1, 24'h00C100);
    captureFrame(f, s, 1'b0, 2'd0, '0);
    checkEq("R9 msb-first order", f, expFrame(8'hC1, 1'b0, 1'b1));
    settle();
    msbFirst = 1'b0;
  endtask

  task automatic testBackToBack();
    logic [10:0] fa, fb;
    int sa, sb;
    hostWrite(2'd0, 24'h0000A3);
    @(negedge clk);
    hostWrite(2'd2, 24'h6E0000);
    captureFrame(fa, sa, 1'b0, 2'd0, '0);
    captureFrame(fb, sb, 1'b0, 2'd0, '0);
    checkEq("R6 first of pair", fa, expFrame(8'hA3, 1'b0, 1'b0));
    checkEq("R6 second of pair", fb, expFrame(8'h6E, 1'b0, 1'b0));
    checkEq("R7 start-to-start spacing", sb - sa, (11 + LEAD) * BIT);
    settle();
  endtask

  task automatic testOverwrite();
    logic [10:0] fa, fb;
    int sa, sb;
    hostWrite(2'd0, 24'h000011);
    @(negedge clk);
    hostWrite(2'd0, 24'h000022);
    hostWrite(2'd0, 24'h000044);
    checkEq("R11 tdre low while pending", tdre, 1'b0);
    captureFrame(fa, sa, 1'b0, 2'd0, '0);
    captureFrame(fb, sb, 1'b0, 2'd0, '0);
    checkEq("R11 first frame", fa, expFrame(8'h11, 1'b0, 1'b0));
    checkEq("R11 replaced byte sent", fb, expFrame(8'h44, 1'b0, 1'b0));
    settle();
    checkEq("R11 nothing else sent", tdre && txd, 1'b1);
  endtask

  task automatic testCollision();
    logic [10:0] fa, fb, fc;
    int sa, sb, sc;
    hostWrite(2'd0, 24'h0000B4);
    @(negedge clk);
    hostWrite(2'd0, 24'h0000C5);
    captureFrame(fa, sa, 1'b1, 2'd0, 24'h0000D6);
    checkEq("R12 tdre stays low on same-cycle write", tdre, 1'b0);
    captureFrame(fb, sb, 1'b0, 2'd0, '0);
    captureFrame(fc, sc, 1'b0, 2'd0, '0);
    checkEq("R12 first frame", fa, expFrame(8'hB4, 1'b0, 1'b0));
    checkEq("R12 shifter took old byte", fb, expFrame(8'hC5, 1'b0, 1'b0));
    checkEq("R12 new byte follows", fc, expFrame(8'hD6, 1'b0, 1'b0));
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLanes();
    testAddress();
    testParity();
    testMsbFirst();
    testBackToBack();
    testOverwrite();
    testCollision();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule